// File: doc/BRIEF.md
# Sampled Partial-Tag Training Array

This block is a compact shadow tag store that watches a handful of chosen sets of a large last-level cache and turns what it sees into training commands for a dead block predictor. Each request carries the cache set index, a partial tag and a partial program counter (PC), plus the predictor's current dead/live verdict for that access. Requests whose set index does not match the sampling pattern are accepted and dropped at once. A request that does match is looked up in a small array with fewer ways than the cache. The array holds only partial tags, partial PCs, a prediction bit, a valid bit and a true-LRU position for each entry.

On a hit the array reports that the PC stored in the entry led to a reuse (train-live). It then records the new PC and verdict in the entry and makes it most recently used. On a miss the new access is always inserted, even when it is predicted dead. An empty way is used if the set has one. Otherwise the entry predicted dead is replaced, and failing that the LRU entry; the replaced entry's PC is reported as having led to a dead block (train-dead). Because the array is separate from the main tag array, its timing does not depend on that array. Its low associativity makes stale tags leave quickly, so training happens sooner.

Top module: `sdp_sampler`

## Requirements
- R1: A request whose set index low bits differ from the sampling pattern is accepted, produces no training command and leaves the array unchanged; `req_ready` is high again on the next cycle.
- R2: With the default parameters (2048 cache sets, 32 sampled sets), a set index is sampled when its bits [5:0] equal 0. Bits [10:6] select one of 32 independent sampled sets.
- R3: A hit (valid entry, equal partial tag) emits a training command with `trn_live`=1 and the PC stored before the access. The entry then keeps the new PC and prediction bit.
- R4: A miss in a set that still has an invalid way fills the lowest-numbered invalid way and emits no training command.
- R5: A miss in a full set evicts the lowest-numbered entry whose prediction bit is 1 (1 means predicted dead). This takes priority over LRU order. It emits `trn_live`=0 with the victim's stored PC.
- R6: A miss in a full set with no predicted-dead entry evicts the least recently used entry and emits `trn_live`=0 with its stored PC.
- R7: A sampled request accepted at clock edge k raises `trn_valid` after edge k+1 when training applies. The command holds stable and `req_ready` stays low until `trn_ready` is seen high.
- R8: After reset `req_ready`=1, `trn_valid`=0 and every entry is invalid.
- R9: The LRU positions within each set always form a permutation of 0..11. On a touch the touched entry becomes position 0 and entries younger than it age by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Array can accept a request |
| req_set | input | 11 | Cache set index of the access |
| req_tag | input | 15 | Partial tag of the access |
| req_pc | input | 15 | Partial PC of the access |
| req_pred | input | 1 | Current verdict for the access, 1 = dead |
| trn_valid | output | 1 | Training command valid |
| trn_ready | input | 1 | Predictor accepts the training command |
| trn_live | output | 1 | 1 = train live, 0 = train dead |
| trn_pc | output | 15 | Stored partial PC to train |

## Verification
Output back-pressure and a new request can fall in the same cycle. The bench holds `trn_ready` low after a hit, raises `req_valid` with a fresh sampled access and keeps both for several cycles. It judges that `req_ready` stays low and that the pending command does not change. After `trn_ready` is released, the waiting request must be taken and must train with the PC that the first hit left in the entry. A second overlap is a predicted-dead entry that is also not the LRU one. The bench arranges it through hits that carry `req_pred`=1, and judges that the dead entry is evicted rather than the LRU one.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  parameter int TAG_W = 15;
  parameter int PC_W  = 15;
  parameter int WAYS  = 12;
  localparam int WAY_W = $clog2(WAYS);

  typedef logic [WAY_W-1:0] way_t;

  typedef struct packed {
    logic             valid;
    logic             pred;
    logic [TAG_W-1:0] tag;
    logic [PC_W-1:0]  pc;
    way_t             pos;   // 0 = most recent, WAYS-1 = least recent
  } entry_t;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_OUT} state_t;

  // recency position of one way after another way (or itself) is touched
  function automatic way_t age_pos(way_t cur, way_t touched_pos, logic self);
    if (self) return '0;
    if (cur < touched_pos) return cur + way_t'(1);
    return cur;
  endfunction
endpackage

// File: rtl/sdp_filter.sv
module sdp_filter #(
  parameter int CSET_W = 11,
  parameter int SIDX_W = 5,
  parameter int PAT    = 0
) (
  input  logic [CSET_W-1:0] set_in,
  output logic              sampled,
  output logic [SIDX_W-1:0] sidx
);
  localparam int STRIDE_W = CSET_W - SIDX_W;

  assign sampled = (set_in[STRIDE_W-1:0] == STRIDE_W'(PAT));
  assign sidx    = set_in[CSET_W-1:STRIDE_W];
endmodule

// File: rtl/sdp_select.sv
module sdp_select
  import sdp_pkg::*;
(
  input  entry_t [WAYS-1:0] row,
  input  logic [TAG_W-1:0]  tag,
  output logic              hit,
  output way_t              hit_way,
  output logic              vic_inv,
  output way_t              vic_way
);
  logic inv_f, dead_f;
  way_t inv_w, dead_w, lru_w;

  always_comb begin
    hit = 1'b0; hit_way = '0;
    inv_f = 1'b0; inv_w = '0;
    dead_f = 1'b0; dead_w = '0;
    lru_w = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit && row[w].valid && row[w].tag == tag) begin
        hit = 1'b1; hit_way = way_t'(w);
      end
      if (!inv_f && !row[w].valid) begin
        inv_f = 1'b1; inv_w = way_t'(w);
      end
      if (!dead_f && row[w].valid && row[w].pred) begin
        dead_f = 1'b1; dead_w = way_t'(w);
      end
      if (row[w].pos == way_t'(WAYS-1)) lru_w = way_t'(w);
    end
    vic_inv = inv_f;
    vic_way = inv_f ? inv_w : (dead_f ? dead_w : lru_w);
  end
endmodule

// File: rtl/sdp_sampler.sv
module sdp_sampler
  import sdp_pkg::*;
#(
  parameter int SETS       = 32,
  parameter int CSET_W     = 11,
  parameter int SAMPLE_PAT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CSET_W-1:0] req_set,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [PC_W-1:0]   req_pc,
  input  logic              req_pred,
  output logic              trn_valid,
  input  logic              trn_ready,
  output logic              trn_live,
  output logic [PC_W-1:0]   trn_pc
);
  localparam int SIDX_W = $clog2(SETS);

  state_t st;
  entry_t mem [SETS][WAYS];
  entry_t [WAYS-1:0] row;

  logic              sampled;
  logic [SIDX_W-1:0] sidx, set_q;
  logic [TAG_W-1:0]  tag_q;
  logic [PC_W-1:0]   pc_q;
  logic              pred_q;
  logic              hit, vic_inv;
  way_t              hit_way, vic_way, touch;
  logic [WAYS-1:0]   pos_mask;

  sdp_filter #(.CSET_W(CSET_W), .SIDX_W(SIDX_W), .PAT(SAMPLE_PAT)) u_filter (
    .set_in(req_set), .sampled(sampled), .sidx(sidx));

  always_comb begin
    pos_mask = '0;
    for (int w = 0; w < WAYS; w++) begin
      row[w] = mem[set_q][w];
      pos_mask[row[w].pos] = 1'b1;
    end
  end

  sdp_select u_select (
    .row(row), .tag(tag_q), .hit(hit), .hit_way(hit_way),
    .vic_inv(vic_inv), .vic_way(vic_way));

  // named events for the checks
  logic accept, ev_drop, ev_hit, ev_fill_inv, ev_evict;
  assign req_ready   = (st == S_IDLE);
  assign accept      = req_valid && req_ready;
  assign ev_drop     = accept && !sampled;
  assign ev_hit      = (st == S_LOOK) && hit;
  assign ev_fill_inv = (st == S_LOOK) && !hit && vic_inv;
  assign ev_evict    = (st == S_LOOK) && !hit && !vic_inv;
  assign touch       = hit ? hit_way : vic_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      trn_valid <= 1'b0;
      trn_live  <= 1'b0;
      trn_pc    <= '0;
      set_q     <= '0;
      tag_q     <= '0;
      pc_q      <= '0;
      pred_q    <= 1'b0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          mem[s][w] <= '{valid: 1'b0, pred: 1'b0, tag: '0, pc: '0, pos: way_t'(w)};
    end else begin
      case (st)
        S_IDLE: if (accept && sampled) begin
          set_q  <= sidx;
          tag_q  <= req_tag;
          pc_q   <= req_pc;
          pred_q <= req_pred;
          st     <= S_LOOK;
        end
        S_LOOK: begin
          for (int w = 0; w < WAYS; w++) begin
            mem[set_q][w].pos <= age_pos(row[w].pos, row[touch].pos, way_t'(w) == touch);
            if (way_t'(w) == touch) begin
              mem[set_q][w].valid <= 1'b1;
              mem[set_q][w].pred  <= pred_q;
              mem[set_q][w].tag   <= tag_q;
              mem[set_q][w].pc    <= pc_q;
            end
          end
          if (hit || !vic_inv) begin
            trn_valid <= 1'b1;
            trn_live  <= hit;
            trn_pc    <= row[touch].pc;
            st        <= S_OUT;
          end else begin
            st <= S_IDLE;
          end
        end
        default: if (trn_ready) begin
          trn_valid <= 1'b0;
          st        <= S_IDLE;
        end
      endcase
    end
  end

  // R1
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> req_ready && !trn_valid);
  // R3
  hit_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> trn_valid && trn_live);
  // R4
  fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_inv |=> !trn_valid && req_ready);
  // R5
  evict_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_evict |=> trn_valid && !trn_live);
  // R7
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trn_valid && !trn_ready |=> trn_valid && $stable(trn_pc) && $stable(trn_live));
  // R7
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trn_valid |-> !req_ready);
  // R9
  lru_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOK) |-> $countones(pos_mask) == WAYS);
endmodule

// File: tb/sdp_sampler_test.sv
module sdp_sampler_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_pred = 1'b0, trn_ready = 1'b0;
  logic [10:0] req_set = '0;
  logic [14:0] req_tag = '0, req_pc = '0;
  logic req_ready, trn_valid, trn_live;
  logic [14:0] trn_pc;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdp_sampler uut (.*);

  task automatic check(bit ok, string name, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", name, act, exp);
    end
  endtask

  function automatic logic [10:0] sset(int idx, int low);
    return 11'((idx << 6) | low);
  endfunction

  // one access; checks timing, kind and PC of the resulting command
  task automatic access(logic [10:0] s, int tag, int pc, bit pred,
                        bit exp_trn, bit exp_live, int exp_pc, string name);
    @(negedge clk);
    req_valid = 1; req_set = s; req_tag = 15'(tag); req_pc = 15'(pc); req_pred = pred;
    @(posedge clk);            // accepted here (array idle)
    @(negedge clk);
    req_valid = 0;
    check(trn_valid == 0, {name, " R7 early"}, trn_valid, 0);
    @(negedge clk);
    check(trn_valid == exp_trn, {name, " valid"}, trn_valid, exp_trn);
    if (exp_trn && trn_valid) begin
      check(trn_live == exp_live, {name, " live"}, trn_live, exp_live);
      check(trn_pc == 15'(exp_pc), {name, " pc"}, trn_pc, exp_pc);
      trn_ready = 1;
      @(negedge clk);
      trn_ready = 0;
    end
    check(req_ready == 1, {name, " ready"}, req_ready, 1);
  endtask

  task automatic t_reset();
    check(req_ready == 1, "R8 ready", req_ready, 1);
    check(trn_valid == 0, "R8 valid", trn_valid, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 12; i++)
      access(sset(3, 0), 100 + i, 200 + i, 0, 0, 0, 0, "R4 fill");
  endtask

  task automatic t_hit();
    access(sset(3, 0), 105, 300, 0, 1, 1, 205, "R3 hit");
    access(sset(3, 0), 105, 301, 0, 1, 1, 300, "R3 newpc");
  endtask

  task automatic t_lru();
    access(sset(3, 0), 500, 600, 0, 1, 0, 200, "R6 lru");
    access(sset(3, 0), 501, 601, 0, 1, 0, 201, "R9 aging");
  endtask

  task automatic t_dead();
    access(sset(3, 0), 108, 350, 1, 1, 1, 208, "R5 mark");
    access(sset(3, 0), 502, 602, 0, 1, 0, 350, "R5 dead first");
    access(sset(3, 0), 110, 360, 1, 1, 1, 210, "R5 mark2");
    access(sset(3, 0), 103, 370, 1, 1, 1, 203, "R5 mark3");
    access(sset(3, 0), 503, 603, 0, 1, 0, 370, "R5 lowest dead");
  endtask

  task automatic t_filter();
    access(sset(3, 5), 105, 999, 0, 0, 0, 0, "R1 drop");
    access(sset(3, 63), 700, 998, 0, 0, 0, 0, "R1 drop2");
    access(sset(3, 0), 105, 400, 0, 1, 1, 301, "R1 untouched");
    access(sset(4, 0), 105, 401, 0, 0, 0, 0, "R2 own set");
    access(sset(4, 0), 105, 402, 0, 1, 1, 401, "R2 sidx hit");
  endtask

  task automatic t_backpressure();
    logic [14:0] held;
    @(negedge clk);
    req_valid = 1; req_set = sset(3, 0); req_tag = 15'(105); req_pc = 15'(410);
    @(posedge clk);
    @(negedge clk);
    req_tag = 15'(105); req_pc = 15'(420);   // next request waits
    @(negedge clk);
    check(trn_valid == 1, "R7 stall valid", trn_valid, 1);
    held = trn_pc;
    check(trn_pc == 15'(400), "R7 stall pc", trn_pc, 400);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(req_ready == 0 && trn_pc == held, "R7 hold", trn_pc, held);
    end
    trn_ready = 1;
    @(negedge clk);        // command taken, idle; request taken next edge
    trn_ready = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    check(trn_valid == 1 && trn_pc == 15'(410), "R7 queued req", trn_pc, 410);
    trn_ready = 1;
    @(negedge clk);
    trn_ready = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_hit();
    t_lru();
    t_dead();
    t_filter();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule